// File: doc/BRIEF.md
# Sleep and Wake Sequencer

This block decides when a small processor core may go to sleep, which clock domains and oscillators stay powered while it sleeps, and how it comes back. Software sets a sleep-enable flag and a three-bit mode code. A sleep instruction then pulses `sleep_insn`. If the flag is set and the code names one of the six supported modes, the sequencer captures the mode and gates the CPU and flash clocks. The I/O, ADC and asynchronous-timer clock domains, the main and timer oscillators and the brown-out detector are kept on or switched off according to that mode.

While the core sleeps, nine wake-request lines are filtered against their interrupt-enable flags and against the set of sources that the captured mode leaves alive. A surviving request, or a core reset request, starts the return path. The oscillator start-up wait runs first, and only after the two modes that stop the main oscillator. A fixed four-cycle CPU hold follows. The sequencer then reopens the CPU clock and pulses either `wake_irq`, meaning the interrupt handler runs and execution then continues after the sleep instruction, or `wake_rst`, meaning execution restarts at the reset vector.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: Sleep is entered only when `sleep_en` is 1 in the cycle `sleep_insn` is 1. Otherwise the pulse leaves `asleep` at 0 and all clocks running.
- R2: Mode codes are 000 idle, 001 ADC noise reduction, 010 power-down, 011 power-save, 110 standby and 111 extended standby. Codes 100 and 101 never cause sleep.
- R3: While asleep, the CPU and flash clocks are off in every mode. Idle keeps the I/O and ADC clocks and the main oscillator on. ADC noise reduction keeps the ADC clock and the main oscillator on. Standby and extended standby keep only the main oscillator on. Power-down and power-save stop all of these.
- R4: The asynchronous-timer clock and the timer oscillator stay on in idle, ADC noise reduction, power-save and extended standby, and only when `tmr_async` is 1. The timer wake source (index 4) is honoured outside idle only when `tmr_async` is 1.
- R5: Wake source indices are 0 and 1 for the external pins, 2 pin change, 3 serial address match, 4 timer, 5 memory ready, 6 ADC, 7 watchdog and 8 other I/O. A request wakes the core only if its `wake_ie` bit is 1 and the mode allows the source. Idle allows all nine. ADC noise reduction allows 0 to 7. Power-save and extended standby allow 0 to 4 and 7. Power-down and standby allow 0 to 3 and 7.
- R6: In every mode except idle and ADC noise reduction, an external pin request (index 0 or 1) wakes the core only if that pin's `ext_level` bit is 1, which marks it as level-triggered.
- R7: `clk_cpu_en` returns D+5 rising edges after the edge that first sees the wake, where D is `startup_cycles` after power-down or power-save and 0 after the other modes. This is one edge to leave sleep, D start-up edges and a four-edge hold.
- R8: On the first cycle with the CPU clock back on, exactly one of `wake_irq` and `wake_rst` is high for one cycle. `wake_rst` is chosen if `core_rst_req` was seen at any point from the wake onward, and that includes the case where it arrives together with an interrupt request.
- R9: `bod_off` is 1 only while asleep in power-down, power-save, standby or extended standby, and only if `bod_req` was 1 at sleep entry. It is 0 during the start-up and hold phases.
- R10: The mode is captured at entry. Changes to `mode_sel` during sleep do not affect the clock enables or the wake sources.
- R11: After reset the sequencer is awake, with the CPU, flash, I/O and ADC clocks and the main oscillator enabled and both wake pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_en | input | 1 | Software sleep-enable flag |
| mode_sel | input | 3 | Sleep mode code |
| sleep_insn | input | 1 | One-cycle pulse from a sleep instruction |
| bod_req | input | 1 | Software request to disable the brown-out detector during sleep |
| tmr_async | input | 1 | Timer runs from its own asynchronous oscillator |
| ext_level | input | 2 | Per external pin: 1 = level-triggered |
| startup_cycles | input | CNT_W | Main-oscillator start-up delay in cycles |
| wake_req | input | 9 | Wake requests, indexed as in R5 |
| wake_ie | input | 9 | Interrupt-enable flags for the wake requests |
| core_rst_req | input | 1 | Reset request observed during sleep |
| clk_cpu_en | output | 1 | CPU clock gate enable |
| clk_flash_en | output | 1 | Flash clock gate enable |
| clk_io_en | output | 1 | I/O clock gate enable |
| clk_adc_en | output | 1 | ADC clock gate enable |
| clk_asy_en | output | 1 | Asynchronous-timer clock gate enable |
| main_osc_en | output | 1 | Main oscillator enable |
| tmr_osc_en | output | 1 | Timer oscillator enable |
| bod_off | output | 1 | Brown-out detector disable |
| asleep | output | 1 | Core is sleeping or waking |
| wake_irq | output | 1 | One-cycle pulse: resume through the interrupt handler |
| wake_rst | output | 1 | One-cycle pulse: resume at the reset vector |

## Verification
The embedded assertions check, on every cycle, the rules that can be read from a short window of the ports. A sleep pulse without the enable flag, or with a reserved code, never puts the core to sleep. The brown-out disable is never active while the I/O clock runs. Each return to a running CPU carries exactly one wake pulse, with the CPU clock off for the four cycles before it. The captured mode does not change while the core sleeps. The per-mode clock table, the source masks, the edge-versus-level rule, the dependence on the asynchronous timer, the exact start-up latency and the reset-over-interrupt priority are shown only by the bench's directed scenarios, each of which drives a mode and compares the outputs against values it computes itself.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

    localparam int NSRC     = 9;
    localparam int HOLD_CYC = 4;

    // wake-source indices
    localparam int SRC_EXT0 = 0;
    localparam int SRC_EXT1 = 1;
    localparam int SRC_TMR  = 4;

    localparam logic [2:0] MD_IDLE  = 3'b000;
    localparam logic [2:0] MD_ADCNR = 3'b001;
    localparam logic [2:0] MD_PDOWN = 3'b010;
    localparam logic [2:0] MD_PSAVE = 3'b011;
    localparam logic [2:0] MD_STBY  = 3'b110;
    localparam logic [2:0] MD_XSTBY = 3'b111;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_SLEEP,
        ST_START,
        ST_HOLD
    } pm_state_e;

    typedef struct packed {
        logic            clk_io;
        logic            clk_adc;
        logic            asy_ok;       // async clock kept if timer is async
        logic            main_osc;
        logic            edge_ok;      // external pins may wake on edges
        logic            bod_ok;       // brown-out disable permitted
        logic            need_startup; // main oscillator was stopped
        logic            tmr_free;     // timer wake not tied to async mode
        logic [NSRC-1:0] src_mask;
    } mode_prof_t;

    function automatic logic mode_ok(input logic [2:0] m);
        return (m[2:1] != 2'b10);
    endfunction

    function automatic mode_prof_t decode_mode(input logic [2:0] m);
        mode_prof_t p;
        p = '0;
        case (m)
            MD_IDLE: begin
                p.clk_io = 1'b1; p.clk_adc = 1'b1; p.asy_ok = 1'b1;
                p.main_osc = 1'b1; p.edge_ok = 1'b1; p.tmr_free = 1'b1;
                p.src_mask = 9'h1FF;
            end
            MD_ADCNR: begin
                p.clk_adc = 1'b1; p.asy_ok = 1'b1; p.main_osc = 1'b1;
                p.edge_ok = 1'b1; p.src_mask = 9'h0FF;
            end
            MD_PDOWN: begin
                p.bod_ok = 1'b1; p.need_startup = 1'b1; p.src_mask = 9'h08F;
            end
            MD_PSAVE: begin
                p.asy_ok = 1'b1; p.bod_ok = 1'b1; p.need_startup = 1'b1;
                p.src_mask = 9'h09F;
            end
            MD_STBY: begin
                p.main_osc = 1'b1; p.bod_ok = 1'b1; p.src_mask = 9'h08F;
            end
            MD_XSTBY: begin
                p.asy_ok = 1'b1; p.main_osc = 1'b1; p.bod_ok = 1'b1;
                p.src_mask = 9'h09F;
            end
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sleep_mode_decode.sv
module sleep_mode_decode
    import sleep_pkg::*;
(
    input  logic [2:0] mode,
    output mode_prof_t prof
);
    assign prof = decode_mode(mode);
endmodule

// File: rtl/sleep_wake_filter.sv
module sleep_wake_filter
    import sleep_pkg::*;
(
    input  mode_prof_t      prof,
    input  logic            tmr_async,
    input  logic [1:0]      ext_level,
    input  logic [NSRC-1:0] wake_req,
    input  logic [NSRC-1:0] wake_ie,
    output logic            wake_any
);
    logic [NSRC-1:0] gate;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (i == SRC_EXT0 || i == SRC_EXT1) begin : g_ext
            assign gate[i] = prof.edge_ok | ext_level[i];
        end else if (i == SRC_TMR) begin : g_tmr
            assign gate[i] = prof.tmr_free | tmr_async;
        end else begin : g_plain
            assign gate[i] = 1'b1;
        end
    end

    assign wake_any = |(wake_req & wake_ie & prof.src_mask & gate);
endmodule

// File: rtl/sleep_wake_seq.sv
module sleep_wake_seq
    import sleep_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enter,
    input  logic [2:0]       mode_in,
    input  logic             bod_in,
    input  logic             wake_any,
    input  logic             rst_req,
    input  logic             need_startup,
    input  logic [CNT_W-1:0] startup_cycles,
    output pm_state_e        st,
    output logic [2:0]       mode_q,
    output logic             bod_q,
    output logic             irq_pulse,
    output logic             rst_pulse
);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);

    pm_state_e        st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             cause_q;
    logic             cause_now;

    assign st        = st_q;
    assign cause_now = cause_q | rst_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_RUN;
            cnt_q     <= '0;
            cause_q   <= 1'b0;
            mode_q    <= MD_IDLE;
            bod_q     <= 1'b0;
            irq_pulse <= 1'b0;
            rst_pulse <= 1'b0;
        end else begin
            irq_pulse <= 1'b0;
            rst_pulse <= 1'b0;
            case (st_q)
                ST_RUN: begin
                    cause_q <= 1'b0;
                    if (enter) begin
                        st_q   <= ST_SLEEP;
                        mode_q <= mode_in;
                        bod_q  <= bod_in;
                    end
                end
                ST_SLEEP: begin
                    if (wake_any || rst_req) begin
                        cause_q <= rst_req;
                        if (need_startup && startup_cycles != '0) begin
                            st_q  <= ST_START;
                            cnt_q <= startup_cycles - 1'b1;
                        end else begin
                            st_q  <= ST_HOLD;
                            cnt_q <= HOLD_LAST;
                        end
                    end
                end
                ST_START: begin
                    cause_q <= cause_now;
                    if (cnt_q == '0) begin
                        st_q  <= ST_HOLD;
                        cnt_q <= HOLD_LAST;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: begin
                    cause_q <= cause_now;
                    if (cnt_q == '0) begin
                        st_q      <= ST_RUN;
                        irq_pulse <= ~cause_now;
                        rst_pulse <= cause_now;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SLEEP) |=> $stable(mode_q)); // R10

    AST_HOLD_BEFORE_RUN: assert property (@(posedge clk) disable iff (rst)
        (irq_pulse || rst_pulse) |-> ($past(st_q, 4) == ST_HOLD)); // R7

    AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !(irq_pulse && rst_pulse)); // R8
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
    import sleep_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_en,
    input  logic [2:0]       mode_sel,
    input  logic             sleep_insn,
    input  logic             bod_req,
    input  logic             tmr_async,
    input  logic [1:0]       ext_level,
    input  logic [CNT_W-1:0] startup_cycles,
    input  logic [8:0]       wake_req,
    input  logic [8:0]       wake_ie,
    input  logic             core_rst_req,
    output logic             clk_cpu_en,
    output logic             clk_flash_en,
    output logic             clk_io_en,
    output logic             clk_adc_en,
    output logic             clk_asy_en,
    output logic             main_osc_en,
    output logic             tmr_osc_en,
    output logic             bod_off,
    output logic             asleep,
    output logic             wake_irq,
    output logic             wake_rst
);
    pm_state_e  st;
    logic [2:0] mode_q;
    logic       bod_q;
    logic       wake_any;
    logic       enter;
    mode_prof_t prof;

    assign enter = sleep_insn & sleep_en & mode_ok(mode_sel);

    sleep_mode_decode u_dec (
        .mode (mode_q),
        .prof (prof)
    );

    sleep_wake_filter u_filt (
        .prof      (prof),
        .tmr_async (tmr_async),
        .ext_level (ext_level),
        .wake_req  (wake_req),
        .wake_ie   (wake_ie),
        .wake_any  (wake_any)
    );

    sleep_wake_seq #(.CNT_W(CNT_W)) u_seq (
        .clk            (clk),
        .rst            (rst),
        .enter          (enter),
        .mode_in        (mode_sel),
        .bod_in         (bod_req),
        .wake_any       (wake_any),
        .rst_req        (core_rst_req),
        .need_startup   (prof.need_startup),
        .startup_cycles (startup_cycles),
        .st             (st),
        .mode_q         (mode_q),
        .bod_q          (bod_q),
        .irq_pulse      (wake_irq),
        .rst_pulse      (wake_rst)
    );

    always_comb begin
        clk_cpu_en   = 1'b1;
        clk_flash_en = 1'b1;
        clk_io_en    = 1'b1;
        clk_adc_en   = 1'b1;
        clk_asy_en   = tmr_async;
        main_osc_en  = 1'b1;
        tmr_osc_en   = tmr_async;
        bod_off      = 1'b0;
        case (st)
            ST_SLEEP, ST_START: begin
                clk_cpu_en   = 1'b0;
                clk_flash_en = 1'b0;
                clk_io_en    = prof.clk_io;
                clk_adc_en   = prof.clk_adc;
                clk_asy_en   = prof.asy_ok & tmr_async;
                tmr_osc_en   = prof.asy_ok & tmr_async;
                main_osc_en  = prof.main_osc | (st == ST_START);
                bod_off      = prof.bod_ok & bod_q & (st == ST_SLEEP);
            end
            ST_HOLD: clk_cpu_en = 1'b0;
            default: ;
        endcase
    end

    assign asleep = (st != ST_RUN);

    AST_NO_ENTRY_WITHOUT_SE: assert property (@(posedge clk) disable iff (rst)
        (!asleep && !(sleep_insn && sleep_en)) |=> !asleep); // R1

    AST_RESERVED_NO_SLEEP: assert property (@(posedge clk) disable iff (rst)
        (!asleep && mode_sel[2:1] == 2'b10) |=> !asleep); // R2

    AST_BOD_ONLY_DEEP: assert property (@(posedge clk) disable iff (rst)
        bod_off |-> (!clk_io_en && !clk_cpu_en)); // R9

    AST_WAKE_PULSE_ON_RESUME: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_cpu_en) |-> $countones({wake_irq, wake_rst}) == 1); // R8
endmodule

// File: tb/sleep_wake_ctrl_tb.sv
module sleep_wake_ctrl_tb;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sleep_en = 1'b0;
    logic [2:0]       mode_sel = 3'b000;
    logic             sleep_insn = 1'b0;
    logic             bod_req = 1'b0;
    logic             tmr_async = 1'b0;
    logic [1:0]       ext_level = 2'b00;
    logic [CNT_W-1:0] startup_cycles = 16'd7;
    logic [8:0]       wake_req = '0;
    logic [8:0]       wake_ie = '0;
    logic             core_rst_req = 1'b0;
    logic clk_cpu_en, clk_flash_en, clk_io_en, clk_adc_en, clk_asy_en;
    logic main_osc_en, tmr_osc_en, bod_off, asleep, wake_irq, wake_rst;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    sleep_wake_ctrl #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .sleep_en(sleep_en), .mode_sel(mode_sel),
        .sleep_insn(sleep_insn), .bod_req(bod_req), .tmr_async(tmr_async),
        .ext_level(ext_level), .startup_cycles(startup_cycles),
        .wake_req(wake_req), .wake_ie(wake_ie), .core_rst_req(core_rst_req),
        .clk_cpu_en(clk_cpu_en), .clk_flash_en(clk_flash_en),
        .clk_io_en(clk_io_en), .clk_adc_en(clk_adc_en),
        .clk_asy_en(clk_asy_en), .main_osc_en(main_osc_en),
        .tmr_osc_en(tmr_osc_en), .bod_off(bod_off), .asleep(asleep),
        .wake_irq(wake_irq), .wake_rst(wake_rst)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // clocks as {cpu, flash, io, adc, asy, main, tmr}
    function automatic int clkvec();
        return {clk_cpu_en, clk_flash_en, clk_io_en, clk_adc_en,
                clk_asy_en, main_osc_en, tmr_osc_en};
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_sleep(input logic [2:0] m, input logic se);
        @(negedge clk);
        mode_sel = m; sleep_en = se; sleep_insn = 1'b1;
        @(negedge clk);
        sleep_insn = 1'b0;
    endtask

    // drive a request, count edges until the CPU clock returns
    task automatic wake_and_time(input logic [8:0] req, input logic rreq,
                                 input int exp_n, input logic exp_rst,
                                 input string tag);
        int n;
        n = 0;
        wake_req = req; core_rst_req = rreq;
        while (n < 100) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            wake_req = '0; core_rst_req = 1'b0;
            if (clk_cpu_en) break;
        end
        chk({tag, " R7 latency"}, n, exp_n);
        chk({tag, " R8 irq pulse"}, wake_irq, !exp_rst);
        chk({tag, " R8 rst pulse"}, wake_rst, exp_rst);
        cyc(1);
        chk({tag, " R8 pulse width"}, wake_irq | wake_rst, 0);
    endtask

    task automatic t_reset();
        chk("R11 clocks", clkvec(), 7'b1111010);
        chk("R11 asleep", asleep, 0);
        chk("R11 pulses", wake_irq | wake_rst, 0);
    endtask

    task automatic t_no_enable();
        go_sleep(3'b010, 1'b0);
        chk("R1 no sleep without enable", asleep, 0);
        chk("R1 cpu clock on", clk_cpu_en, 1);
    endtask

    task automatic t_reserved();
        go_sleep(3'b100, 1'b1);
        chk("R2 code 100", asleep, 0);
        go_sleep(3'b101, 1'b1);
        chk("R2 code 101", asleep, 0);
    endtask

    task automatic t_idle();
        tmr_async = 1'b0; wake_ie = 9'h1FF;
        go_sleep(3'b000, 1'b1);
        chk("R1 idle entered", asleep, 1);
        chk("R3 idle clocks", clkvec(), 7'b0011010);
        wake_and_time(9'h100, 1'b0, 5, 1'b0, "idle other-io");
    endtask

    task automatic t_adcnr();
        wake_ie = 9'h1FF;
        go_sleep(3'b001, 1'b1);
        chk("R3 adcnr clocks", clkvec(), 7'b0001010);
        wake_req = 9'h100;
        cyc(3);
        chk("R5 adcnr other-io masked", asleep, 1);
        wake_req = '0;
        wake_and_time(9'h040, 1'b0, 5, 1'b0, "adcnr adc");
    endtask

    task automatic t_pdown();
        ext_level = 2'b00; bod_req = 1'b1; wake_ie = 9'h17F;
        go_sleep(3'b010, 1'b1);
        chk("R3 pdown clocks", clkvec(), 7'b0000000);
        chk("R9 bod off in pdown", bod_off, 1);
        wake_req = 9'h001;
        cyc(3);
        chk("R6 edge ext0 blocked", asleep, 1);
        wake_req = 9'h080;
        cyc(3);
        chk("R5 watchdog ie clear blocked", asleep, 1);
        wake_req = 9'h040;
        cyc(3);
        chk("R5 adc masked in pdown", asleep, 1);
        wake_req = '0;
        ext_level = 2'b01;
        wake_and_time(9'h001, 1'b0, 12, 1'b0, "pdown level ext0");
        chk("R9 bod on after wake", bod_off, 0);
        bod_req = 1'b0; ext_level = 2'b00;
    endtask

    task automatic t_psave();
        wake_ie = 9'h1FF; tmr_async = 1'b0;
        go_sleep(3'b011, 1'b1);
        chk("R4 psave sync timer clocks", clkvec(), 7'b0000000);
        chk("R9 bod stays on without request", bod_off, 0);
        wake_req = 9'h010;
        cyc(3);
        chk("R4 sync timer wake blocked", asleep, 1);
        wake_req = '0;
        tmr_async = 1'b1;
        cyc(1);
        chk("R4 psave async clocks", clkvec(), 7'b0000101);
        wake_and_time(9'h010, 1'b0, 12, 1'b0, "psave timer");
        tmr_async = 1'b0;
    endtask

    task automatic t_stby();
        wake_ie = 9'h1FF; bod_req = 1'b1;
        go_sleep(3'b110, 1'b1);
        chk("R3 standby clocks", clkvec(), 7'b0000010);
        chk("R9 bod off in standby", bod_off, 1);
        wake_and_time(9'h080, 1'b0, 5, 1'b0, "standby wdt");
        go_sleep(3'b000, 1'b1);
        chk("R9 idle keeps bod", bod_off, 0);
        wake_and_time(9'h008, 1'b0, 5, 1'b0, "idle twi");
        bod_req = 1'b0;
    endtask

    task automatic t_xstby();
        wake_ie = 9'h1FF; tmr_async = 1'b1;
        go_sleep(3'b111, 1'b1);
        chk("R4 ext standby async clocks", clkvec(), 7'b0000111);
        wake_req = 9'h020;
        cyc(3);
        chk("R5 mem-ready masked in ext standby", asleep, 1);
        wake_req = '0;
        wake_and_time(9'h010, 1'b0, 5, 1'b0, "xstby timer");
        tmr_async = 1'b0;
    endtask

    task automatic t_reset_wake();
        wake_ie = 9'h1FF;
        go_sleep(3'b010, 1'b1);
        wake_and_time(9'h004, 1'b1, 12, 1'b1, "pdown reset+pc");
        go_sleep(3'b000, 1'b1);
        wake_and_time(9'h000, 1'b1, 5, 1'b1, "idle reset");
    endtask

    task automatic t_mode_latch();
        wake_ie = 9'h1FF;
        go_sleep(3'b000, 1'b1);
        mode_sel = 3'b010;
        cyc(2);
        chk("R10 io clock kept", clk_io_en, 1);
        wake_and_time(9'h100, 1'b0, 5, 1'b0, "R10 latched idle");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        t_reset();
        t_no_enable();
        t_reserved();
        t_idle();
        t_adcnr();
        t_pdown();
        t_psave();
        t_stby();
        t_xstby();
        t_reset_wake();
        t_mode_latch();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule